// File: doc/BRIEF.md
# PCI Target Termination Controller

This block sits between the bus-facing side of a PCI target and the user application behind it. For every transaction addressed to the target, it decides how that transaction ends. The outcome is one of three: a normal data transfer, a target abort, or a retry, which is a disconnect with no data moved. The application asks for an abort with a level input that is active high. It asks for a retry with a level input that is active low. Both inputs are synchronous to the PCI clock, so no synchronizer stages are added. The block samples both inputs only at the address phase. The outcome is then frozen for the whole transaction.

The block drives DEVSEL#, TRDY# and STOP#. It also owns the back-end stream towards the application, which carries the address, the write data and the direction for each beat. On a retry or an abort this stream stays silent.

The back-end beat interface follows valid/ready rules:
- `be_valid` is raised only in a normal transfer, while IRDY# is asserted.
- A beat completes on a clock where `be_valid` and `be_ready` are both high.
- Holding `be_ready` low withholds TRDY#. This inserts wait states on the bus, and the beat's address and data stay unchanged.

Top module: `pci_tgt_term_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low puts the block in idle. From the following cycle, `devsel_n`, `trdy_n` and `stop_n` are high and `be_valid` is low. This holds even if reset arrives in the middle of a transaction.
- R2: A transaction starts at a clock edge that sees all three of the following: `frame_n` low, `frame_n` high at the previous edge, and `addr_hit` high. After that edge there is one decode cycle with all bus outputs high. A normal transfer or a retry asserts `devsel_n` after the next edge. An abort asserts `devsel_n` after the next edge for one cycle only (R6).
- R3: `abort_req` and `retry_req_n` are used only at the start edge. Changing them later in the transaction has no effect on its outcome or its outputs.
- R4: In a normal transfer, `devsel_n` is low, `stop_n` is high and `trdy_n` equals the inverse of `be_ready`. `be_valid` equals the inverse of `irdy_n`. `be_write` is the `cmd_write` value captured at the start edge. The first beat's `be_addr` is the value of `ad_in` at the start edge, and each completed beat adds DATA_W/8 to it. `be_wdata` follows `ad_in`. `ad_out` follows `be_rdata`, and `ad_oe` is high only in a read transfer.
- R5: A normal transfer ends at the edge that completes a beat while `frame_n` is high.
- R6: With `abort_req` high at the start edge, `devsel_n` and `stop_n` are low for one cycle. Then `devsel_n` is high while `stop_n` stays low, until an edge sees `frame_n` high. `trdy_n` stays high throughout. Every new access is aborted while `abort_req` stays high.
- R7: With `retry_req_n` low at the start edge, and abort not requested, `devsel_n` and `stop_n` are low and `trdy_n` is high until an edge sees `frame_n` high.
- R8: During an abort or a retry, `be_valid` stays low, so no beat reaches the application.
- R9: If both requests are active at the start edge, the transaction is aborted.
- R10: After any transaction there is exactly one cycle with `devsel_n`, `trdy_n` and `stop_n` all high before idle.
- R11: `trdy_n` and `stop_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| addr_hit | input | 1 | Address decode hit during the address phase |
| cmd_write | input | 1 | Command direction at the address phase, 1 = write |
| ad_in | input | ADDR_W | Address at the address phase, write data in data phases |
| abort_req | input | 1 | Application abort request, active high |
| retry_req_n | input | 1 | Application retry request, active low |
| devsel_n | output | 1 | DEVSEL# drive |
| trdy_n | output | 1 | TRDY# drive |
| stop_n | output | 1 | STOP# drive |
| ad_out | output | DATA_W | Read data towards the bus |
| ad_oe | output | 1 | Read data enable |
| be_valid | output | 1 | Back-end beat valid |
| be_ready | input | 1 | Back-end beat ready |
| be_write | output | 1 | Beat direction, 1 = write |
| be_addr | output | ADDR_W | Beat address |
| be_wdata | output | DATA_W | Beat write data |
| be_rdata | input | DATA_W | Read data from the application |

## Verification
Two registers sit between an address phase and the response:
- The start edge moves the block to decode, so the bus outputs are still high in the following cycle.
- The next edge selects the outcome, so DEVSEL# is due two edges after the address phase.

In a normal transfer, TRDY# and `be_valid` are combinational from `be_ready` and IRDY#. They are therefore checked in the same cycle as the input change. The beat address advances at the edge that completes a beat. Termination is left at the edge that first sees FRAME# high, and the all-high turnaround cycle follows one edge later. Inputs are driven at the falling clock edge and outputs are read 2 ns later, which keeps every check on the cycle counted above. A monitor compares each completed beat against a queue of expected beats, which the driver fills.

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_XFER, ST_ABORT, ST_RETRY, ST_TA
  } term_state_t;

  typedef enum logic [1:0] {
    OUT_NORMAL, OUT_ABORT, OUT_RETRY
  } term_out_t;
endpackage

// File: rtl/pci_term_decide.sv
// Start detection and frozen termination choice.
module pci_term_decide
  import pci_term_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_idle,
  input  logic      frame_n,
  input  logic      addr_hit,
  input  logic      cmd_write,
  input  logic      abort_req,
  input  logic      retry_req_n,
  output logic      start,
  output term_out_t outcome,
  output logic      wr_q
);
  logic frame_q;

  assign start = in_idle && frame_q && !frame_n && addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      outcome <= OUT_NORMAL;
      wr_q    <= 1'b0;
    end else begin
      frame_q <= frame_n;
      if (start) begin
        wr_q <= cmd_write;
        if (abort_req)
          outcome <= OUT_ABORT;
        else if (!retry_req_n)
          outcome <= OUT_RETRY;
        else
          outcome <= OUT_NORMAL;
      end
    end
  end
endmodule

// File: rtl/pci_term_fsm.sv
// Termination sequencer and bus control drive.
module pci_term_fsm
  import pci_term_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  term_out_t   outcome,
  input  logic        frame_n,
  input  logic        beat,
  input  logic        be_ready,
  output term_state_t state,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n
);
  term_state_t nxt;
  logic        abort_first;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (outcome)
          OUT_ABORT: nxt = ST_ABORT;
          OUT_RETRY: nxt = ST_RETRY;
          default:   nxt = ST_XFER;
        endcase
      end
      ST_XFER:   if (beat && frame_n) nxt = ST_TA;
      ST_ABORT:  if (!abort_first && frame_n) nxt = ST_TA;
      ST_RETRY:  if (frame_n) nxt = ST_TA;
      ST_TA:     nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      abort_first <= 1'b0;
    end else begin
      state       <= nxt;
      abort_first <= (state == ST_DECODE) && (nxt == ST_ABORT);
    end
  end

  assign devsel_n = !((state == ST_XFER) || (state == ST_RETRY) ||
                      ((state == ST_ABORT) && abort_first));
  assign stop_n   = !((state == ST_ABORT) || (state == ST_RETRY));
  assign trdy_n   = !((state == ST_XFER) && be_ready);
endmodule

// File: rtl/pci_term_backend.sv
// Back-end beat stream, gated to normal transfers only.
module pci_term_backend #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              xfer,
  input  logic              wr_q,
  input  logic              irdy_n,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic              be_ready,
  input  logic [DATA_W-1:0] be_rdata,
  output logic              be_valid,
  output logic              beat,
  output logic              be_write,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);
  localparam int STEP = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  assign be_valid = xfer && !irdy_n;
  assign beat     = be_valid && be_ready;
  assign be_write = wr_q;
  assign be_wdata = ad_in[DATA_W-1:0];
  assign ad_out   = be_rdata;
  assign ad_oe    = xfer && !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      be_addr <= '0;
    else if (start)
      be_addr <= ad_in;
    else if (beat)
      be_addr <= be_addr + STEP_V;
  end
endmodule

// File: rtl/pci_tgt_term_ctrl.sv
module pci_tgt_term_ctrl
  import pci_term_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              addr_hit,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic              abort_req,
  input  logic              retry_req_n,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              be_valid,
  input  logic              be_ready,
  output logic              be_write,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  input  logic [DATA_W-1:0] be_rdata
);
  term_state_t fsm_state;
  term_out_t   outcome;
  logic        start, wr_q, beat;

  pci_term_decide u_decide (
    .clk(clk), .rst_n(rst_n), .in_idle(fsm_state == ST_IDLE),
    .frame_n(frame_n), .addr_hit(addr_hit), .cmd_write(cmd_write),
    .abort_req(abort_req), .retry_req_n(retry_req_n),
    .start(start), .outcome(outcome), .wr_q(wr_q)
  );

  pci_term_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .outcome(outcome),
    .frame_n(frame_n), .beat(beat), .be_ready(be_ready),
    .state(fsm_state), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
  );

  pci_term_backend #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_backend (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer(fsm_state == ST_XFER),
    .wr_q(wr_q), .irdy_n(irdy_n), .ad_in(ad_in), .be_ready(be_ready),
    .be_rdata(be_rdata), .be_valid(be_valid), .beat(beat),
    .be_write(be_write), .be_addr(be_addr), .be_wdata(be_wdata),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );
endmodule

// File: rtl/pci_term_chk.sv
module pci_term_chk
  import pci_term_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        stop_n,
  input logic        be_valid,
  input term_state_t st
);
  // R11
  trdy_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && !stop_n));

  // R8
  backend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid |-> (stop_n && !devsel_n));

  // R6
  abort_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && devsel_n) |=> devsel_n);

  // R3
  frozen_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER || st == ST_ABORT || st == ST_RETRY) |=>
      (st == ST_TA || st == $past(st)));

  // R10
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(devsel_n) && stop_n) |=> (devsel_n && trdy_n && stop_n));
endmodule

bind pci_tgt_term_ctrl pci_term_chk u_chk (
  .clk(clk), .rst_n(rst_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
  .stop_n(stop_n), .be_valid(be_valid), .st(fsm_state)
);

// File: tb/pci_tgt_term_ctrl_tb_top.sv
`timescale 1ns/1ps
module pci_tgt_term_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n, frame_n, irdy_n, addr_hit, cmd_write, abort_req, retry_req_n;
  logic [AW-1:0] ad_in;
  logic devsel_n, trdy_n, stop_n, ad_oe, be_valid, be_ready, be_write;
  logic [DW-1:0] ad_out, be_wdata, be_rdata;
  logic [AW-1:0] be_addr;

  typedef struct { logic [31:0] a; logic [31:0] d; logic w; } beat_t;
  beat_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_tgt_term_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .addr_hit(addr_hit), .cmd_write(cmd_write), .ad_in(ad_in),
    .abort_req(abort_req), .retry_req_n(retry_req_n),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .be_valid(be_valid), .be_ready(be_ready),
    .be_write(be_write), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_rdata(be_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bus(input string req, input logic dv, input logic tr,
                           input logic sp);
    check({devsel_n, trdy_n, stop_n} == {dv, tr, sp}, req,
          {29'd0, devsel_n, trdy_n, stop_n}, {29'd0, dv, tr, sp});
  endtask

  function automatic logic [31:0] beat_data(input logic [31:0] a, input int i);
    return {a[15:0], 16'(i)} ^ 32'h5A5A_0000;
  endfunction

  // Monitor: pop and compare each completed beat.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (be_valid && be_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected beat", be_addr, 32'h0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(be_addr == e.a, "R4 beat address", be_addr, e.a);
          check(be_write == e.w, "R4 beat direction", {31'd0, be_write}, {31'd0, e.w});
          if (e.w)
            check(be_wdata == e.d, "R4 write data", be_wdata, e.d);
          else
            check(ad_out == e.d && ad_oe, "R4 read data", ad_out, e.d);
        end
      end
    end
  end

  // Normal transfer of n beats; stall_at inserts one wait state on that beat;
  // poke raises both requests after the start edge (R3).
  task automatic txn_normal(input logic [31:0] a, input bit wr, input int n,
                            input int stall_at, input bit poke);
    @(negedge clk);
    frame_n = 0; addr_hit = 1; ad_in = a; cmd_write = wr; irdy_n = 1;
    #2 check_bus("R2 idle at address phase", 1, 1, 1);
    @(negedge clk);
    addr_hit = 0; ad_in = '0;
    #2 check_bus("R2 decode cycle", 1, 1, 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      irdy_n = 0; ad_in = beat_data(a, i); be_rdata = beat_data(a, i);
      frame_n = (i == n - 1);
      if (poke && i == 0) begin abort_req = 1; retry_req_n = 0; end
      if (i == stall_at) begin
        be_ready = 0;
        #2 check_bus("R4 wait state", 0, 1, 1);
        check(be_valid == 1, "R4 valid held in wait", {31'd0, be_valid}, 32'd1);
        @(negedge clk);
        be_ready = 1;
      end
      #2 check_bus(poke ? "R3 late request ignored" : "R4 data phase", 0, 0, 1);
      exp_q.push_back('{a + 32'(4 * i), beat_data(a, i), wr});
    end
    @(negedge clk);
    irdy_n = 1; frame_n = 1; abort_req = 0; retry_req_n = 1;
    #2 check_bus("R5 R10 turnaround", 1, 1, 1);
    check(be_valid == 0, "R5 no beat after end", {31'd0, be_valid}, 32'd0);
    @(negedge clk);
    #2 check_bus("R10 idle", 1, 1, 1);
  endtask

  // Abort/retry transaction; requests released after the start edge (R3).
  task automatic txn_term(input logic [31:0] a, input bit ab, input bit rt,
                          input bit exp_abort);
    @(negedge clk);
    frame_n = 0; addr_hit = 1; ad_in = a; cmd_write = 1; irdy_n = 1;
    abort_req = ab; retry_req_n = !rt;
    #2 check_bus("R2 idle at address phase", 1, 1, 1);
    @(negedge clk);
    addr_hit = 0; abort_req = 0; retry_req_n = 1;
    #2 check_bus("R2 decode cycle", 1, 1, 1);
    @(negedge clk);
    irdy_n = 0; ad_in = 32'hDEAD_BEEF;
    #2 check_bus(exp_abort ? "R6 R9 abort first" : "R7 retry", 0, 1, 0);
    check(be_valid == 0, "R8 no strobe", {31'd0, be_valid}, 32'd0);
    @(negedge clk);
    frame_n = 1;
    #2 if (exp_abort) check_bus("R6 abort hold", 1, 1, 0);
       else check_bus("R7 retry hold", 0, 1, 0);
    check(be_valid == 0, "R8 no strobe", {31'd0, be_valid}, 32'd0);
    @(negedge clk);
    irdy_n = 1;
    #2 check_bus("R10 turnaround", 1, 1, 1);
    @(negedge clk);
    #2 check_bus("R10 idle", 1, 1, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; frame_n = 1; irdy_n = 1; addr_hit = 0; cmd_write = 0;
    ad_in = '0; abort_req = 0; retry_req_n = 1; be_ready = 1; be_rdata = '0;
    repeat (3) @(negedge clk);
    #2 check_bus("R1 reset state", 1, 1, 1);
    check(be_valid == 0, "R1 reset valid", {31'd0, be_valid}, 32'd0);
    @(negedge clk); rst_n = 1;

    txn_normal(32'h0000_1000, 1'b1, 1, -1, 1'b0);
    txn_normal(32'h0000_2000, 1'b1, 4, 2, 1'b0);
    txn_normal(32'h0000_3000, 1'b0, 3, 0, 1'b0);
    txn_normal(32'h0000_4000, 1'b1, 2, -1, 1'b1);
    txn_term(32'h0000_5000, 1'b1, 1'b0, 1'b1);
    txn_term(32'h0000_5100, 1'b1, 1'b0, 1'b1);
    txn_term(32'h0000_6000, 1'b0, 1'b1, 1'b0);
    txn_term(32'h0000_7000, 1'b1, 1'b1, 1'b1);
    txn_normal(32'h0000_8000, 1'b0, 2, -1, 1'b0);

    // R1: reset in the middle of a transfer
    @(negedge clk);
    frame_n = 0; addr_hit = 1; ad_in = 32'h9000;
    @(negedge clk); addr_hit = 0;
    @(negedge clk);
    #2 check_bus("R1 pre-reset transfer", 0, 0, 1);
    be_ready = 0; rst_n = 0;
    @(negedge clk);
    frame_n = 1; be_ready = 1;
    #2 check_bus("R1 reset mid transaction", 1, 1, 1);
    check(be_valid == 0, "R1 reset valid", {31'd0, be_valid}, 32'd0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    check(exp_q.size() == 0, "R4 all beats seen", exp_q.size(), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule